// File: doc/BRIEF.md
# Edge-Window Signal Qualifier

This block sits behind a demodulator and decides whether the serial line carries a real transmitter or only noise. It times the gap between successive edges of the demodulated line in system-clock cycles and compares each gap with an acceptance window, given as a lower and an upper limit. Coding schemes with two edges per bit, such as Manchester or bi-phase, give two gap tests per bit. The number of bits to qualify is a 2-bit setting.

A start pulse samples the window limits and the bit setting. The block then waits for the first edge, which only begins timing. After that it tests every gap. When enough gaps have passed, it enters the receiving mode and forwards the synchronized data to its output. The first gap that is too short or too long ends the check. The block then pulses a fail flag and sleeps until the next start pulse.

Top module: `edge_window_qualifier`

## Requirements
- R1: While reset is asserted and right after it, `mode_o` is 0 (sleep), and `data_o` and `fail_o` are 0.
- R2: A start pulse samples the limits and `bits_sel_i`. A `bits_sel_i` of 0 moves the block straight to receiving (`mode_o` = 3) one cycle after the pulse.
- R3: After a start with a nonzero setting, the block waits in mode 1 for as long as no edge arrives. The first edge moves it to mode 2 and is not counted as a tested gap.
- R4: A gap of G cycles between edges passes when min ≤ G ≤ max. `bits_sel_i` value s asks for 6·s passing gaps, so the values 0, 1, 2 and 3 mean 0, 3, 6 and 9 bits. The last required pass enters mode 3.
- R5: A gap with G < min ends the check in mode 0 and gives one fail pulse.
- R6: When no edge has come for max+1 cycles, the check fails at once, without waiting for the next edge, and the block returns to mode 0.
- R7: `fail_o` is high for exactly one cycle per failure. After a failure the block stays in mode 0 through any data activity until a new start pulse.
- R8: In mode 3, `data_o` follows `data_i` two clock cycles late (the synchronizer depth). In every other mode `data_o` is 0.
- R9: Changes on `win_min_i`, `win_max_i` and `bits_sel_i` after the start pulse have no effect on the running check.
- R10: The encoding of `mode_o` is 0 sleep, 1 waiting for the first edge, 2 checking gaps, 3 receiving.
- R11: A start pulse restarts the sequence from any mode, including receiving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that samples the settings and begins qualification |
| data_i | input | 1 | Demodulated serial line, asynchronous to the clock |
| win_min_i | input | CNT_W | Shortest accepted gap between edges, in cycles |
| win_max_i | input | CNT_W | Longest accepted gap between edges, in cycles |
| bits_sel_i | input | SEL_W | Number of bits to qualify, in steps of three bits |
| mode_o | output | 2 | Current mode, encoded as in R10 |
| data_o | output | 1 | Synchronized data while receiving, 0 otherwise |
| fail_o | output | 1 | One-cycle pulse when a gap violates the window |

## Verification
The bench sweeps the gap length from one cycle up to two cycles past the upper limit, for every nonzero bit setting and for several windows. This makes a design that is off by one at either limit accept or reject the wrong gap. It checks that the mode is still 2 just before the final gap, so a design that counts the first edge, or that counts 6·s wrongly, enters receiving one gap early or late. A dedicated case times the timeout to the exact cycle: waiting for the next edge would make it late, and comparing with ≥ would make it early. The settings are changed right after every start, and data keeps toggling after a failure. A design that reads its settings live, or that wakes from sleep on its own, ends in the wrong mode.

// File: rtl/ewq_pkg.sv
package ewq_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_ARM   = 2'd1,
    MODE_CHECK = 2'd2,
    MODE_RECV  = 2'd3
  } ewq_mode_e;
endpackage

// File: rtl/ewq_edge_sync.sv
module ewq_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic level_o,
  output logic edge_o
);
  // one extra stage holds the previous synchronized level
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], din_i};
  end

  assign level_o = sh_q[SYNC_STAGES-1];
  assign edge_o  = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/ewq_interval_timer.sv
module ewq_interval_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic [CNT_W-1:0] cnt_q;

  // counts cycles since the last edge and saturates at the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (edge_i)           cnt_q <= CNT_W'(1);
    else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  assert_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> cnt_o == CNT_W'(1));
endmodule

// File: rtl/edge_window_qualifier.sv
module edge_window_qualifier
  import ewq_pkg::*;
#(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned SEL_W         = 2,
  parameter int unsigned BITS_PER_STEP = 3,
  parameter int unsigned EDGES_PER_BIT = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             data_i,
  input  logic [CNT_W-1:0] win_min_i,
  input  logic [CNT_W-1:0] win_max_i,
  input  logic [SEL_W-1:0] bits_sel_i,
  output logic [1:0]       mode_o,
  output logic             data_o,
  output logic             fail_o
);
  localparam int unsigned STEP_CHECKS = BITS_PER_STEP * EDGES_PER_BIT;
  localparam int unsigned MAX_CHECKS  = ((1 << SEL_W) - 1) * STEP_CHECKS;
  localparam int unsigned LEFT_W      = $clog2(MAX_CHECKS + 1);

  ewq_mode_e        state_q;
  logic [CNT_W-1:0] min_q, max_q, cnt;
  logic [LEFT_W-1:0] left_q, need;
  logic             fail_q, level, edge_det, too_short, too_long;

  ewq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (data_i),
    .level_o (level),
    .edge_o  (edge_det)
  );

  ewq_interval_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (edge_det),
    .cnt_o  (cnt)
  );

  assign need      = LEFT_W'(int'(bits_sel_i) * STEP_CHECKS);
  assign too_short = edge_det && (cnt < min_q);
  assign too_long  = cnt > max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MODE_SLEEP;
      min_q   <= '0;
      max_q   <= '0;
      left_q  <= '0;
      fail_q  <= 1'b0;
    end else begin
      fail_q <= 1'b0;
      if (start_i) begin
        min_q   <= win_min_i;
        max_q   <= win_max_i;
        left_q  <= need;
        state_q <= (need == '0) ? MODE_RECV : MODE_ARM;
      end else begin
        unique case (state_q)
          MODE_ARM: if (edge_det) state_q <= MODE_CHECK;
          MODE_CHECK: begin
            if (too_short || too_long) begin
              state_q <= MODE_SLEEP;
              fail_q  <= 1'b1;
            end else if (edge_det) begin
              left_q <= left_q - LEFT_W'(1);
              if (left_q == LEFT_W'(1)) state_q <= MODE_RECV;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mode_o = state_q;
  assign data_o = (state_q == MODE_RECV) && level;
  assign fail_o = fail_q;

  assert_fail_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);
  assert_sleep_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_SLEEP && !start_i) |=> state_q == MODE_SLEEP);
  assert_fail_to_sleep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> mode_o == 2'd0);
  assert_data_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd3) |-> !data_o);
  assert_recv_on_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_RECV && $past(state_q) == MODE_CHECK && !$past(start_i))
      |-> $past(edge_det));
  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(min_q) && $stable(max_q)));
endmodule

// File: tb/test_edge_window_qualifier.sv
module test_edge_window_qualifier;
  localparam int CNT_W = 8;
  localparam int SEL_W = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, data_r = 1'b0;
  logic [CNT_W-1:0] wmin = '0, wmax = '0;
  logic [SEL_W-1:0] sel = '0;
  logic [1:0] mode;
  logic dout, fail;

  int n_tests = 0, n_fail = 0, fail_seen = 0;
  logic fail_prev = 1'b0;

  always #4 clk = ~clk;

  edge_window_qualifier #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_edge_window_qualifier (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data_r),
    .win_min_i(wmin), .win_max_i(wmax), .bits_sel_i(sel),
    .mode_o(mode), .data_o(dout), .fail_o(fail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R7 monitor: pulse width and count
  always @(negedge clk) begin
    if (rst_n && fail) fail_seen++;
    if (rst_n && fail && fail_prev) begin
      n_tests++; n_fail++;
      $display("FAIL R7 fail pulse wider than one cycle: actual 2 expected 1");
    end
    fail_prev = fail;
  end

  task automatic do_start(input int s, input int mn, input int mx);
    sel = SEL_W'(s); wmin = CNT_W'(mn); wmax = CNT_W'(mx); start = 1'b1;
    cyc(1);
    start = 1'b0;
    // R9: scramble settings after sampling
    sel = '0; wmin = 8'd200; wmax = 8'd1;
  endtask

  task automatic run_case(input int s, input int mn, input int mx, input int p);
    int f0;
    bit pass;
    f0 = fail_seen;
    pass = (mn <= p) && (p <= mx);
    do_start(s, mn, mx);
    cyc(3);
    for (int i = 0; i <= 6 * s; i++) begin
      if (i == 6 * s && pass)
        chk(mode == 2'd2, "R4", "mode before last gap", mode, 2);
      data_r = ~data_r;
      cyc(p);
    end
    cyc(mx + 6);
    if (pass) begin
      chk(mode == 2'd3, "R4", $sformatf("recv s=%0d win=%0d..%0d gap=%0d", s, mn, mx, p), mode, 3);
      chk(fail_seen == f0, "R9", "no fail with scrambled settings", fail_seen - f0, 0);
      chk(dout == data_r, "R8", "data passed in recv", dout, data_r);
    end else begin
      chk(mode == 2'd0, (p < mn) ? "R5" : "R6",
          $sformatf("sleep s=%0d win=%0d..%0d gap=%0d", s, mn, mx, p), mode, 0);
      chk(fail_seen == f0 + 1, "R7", "one fail pulse", fail_seen - f0, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    cyc(3);
    chk(mode == 2'd0 && !dout && !fail, "R1", "in reset", mode, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(mode == 2'd0, "R1", "after reset mode", mode, 0);
    chk(!dout && !fail, "R1", "after reset outputs", dout | fail, 0);

    // R2: zero bits goes straight to receiving
    data_r = 1'b1;
    cyc(4);
    do_start(0, 2, 6);
    chk(mode == 2'd3, "R2", "zero bits to recv", mode, 3);
    cyc(2);
    chk(dout == 1'b1, "R8", "data high in recv", dout, 1);
    data_r = 1'b0;
    cyc(1);
    chk(dout == 1'b1, "R8", "one cycle late still old", dout, 1);
    cyc(1);
    chk(dout == 1'b0, "R8", "two cycles late follows", dout, 0);

    // R11: restart from receiving
    do_start(1, 2, 6);
    chk(mode == 2'd1, "R11", "restart from recv to arm", mode, 1);
    cyc(20);
    chk(mode == 2'd1, "R3", "no timeout before first edge", mode, 1);
    data_r = 1'b1;
    cyc(2);
    chk(mode == 2'd1, "R3", "first edge not yet seen", mode, 1);
    cyc(1);
    chk(mode == 2'd2, "R3", "first edge starts check", mode, 2);

    // R6: exact timeout cycle, max = 6
    cyc(1);
    data_r = 1'b0;
    n = 0;
    while (!fail && n < 40) begin cyc(1); n++; end
    chk(n == 10, "R6", "timeout cycle after last edge", n, 10);
    chk(mode == 2'd0, "R6", "sleep after timeout", mode, 0);

    // R7/R8: activity in sleep ignored
    data_r = 1'b1;
    cyc(4);
    data_r = 1'b0;
    cyc(4);
    data_r = 1'b1;
    cyc(4);
    chk(mode == 2'd0, "R7", "stays asleep on edges", mode, 0);
    chk(dout == 1'b0, "R8", "data gated in sleep", dout, 0);

    for (int s = 1; s <= 3; s++)
      for (int w = 0; w < 3; w++) begin
        int mn, mx;
        mn = (w == 0) ? 2 : (w == 1) ? 3 : 4;
        mx = (w == 0) ? 6 : (w == 1) ? 3 : 9;
        for (int p = 1; p <= mx + 2; p++) run_case(s, mn, mx, p);
      end

    chk(mode inside {2'd0, 2'd3}, "R10", "mode code valid at end", mode, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule